// File: doc/BRIEF.md
# Dual-Input Up/Down Cascadable Counter Stage

This block is a synchronous binary counter stage, four bits wide by default. It has no direction pin. Instead it takes two count inputs, one that steps the value up and one that steps it down. Both inputs idle high. A stage moves one step when one of these inputs goes from low to high while the other input stays high. A parallel preset copies a data word into the stage while the active-low load input is held low. An active-high clear forces the value to zero and overrides everything else.

The whole stage runs on one system clock. The count inputs are treated as levels sampled on that clock, and an edge detector on each input finds its low-to-high transitions. All state bits change on the same clock edge. The terminal outputs are active low. The carry output goes low while the stage holds its maximum value and the up input is low. The borrow output goes low while the stage holds zero and the down input is low. Each pulse therefore follows the low phase of the input that caused it. To chain stages, wire each stage's carry to the next stage's up input and its borrow to the next stage's down input. Longer counters then need no extra logic.

Top module: `updn_stage`

## Requirements
- R1: After reset, with both count inputs high, load_n_i high and clr_i low, count_o reads 0 and both carry_n_o and borrow_n_o read 1.
- R2: A low-to-high transition of up_i while dn_i is high adds one to count_o. The new value appears after the clock edge that first samples up_i high. The maximum value (all ones) wraps to 0.
- R3: A low-to-high transition of dn_i while up_i is high subtracts one from count_o, with the same timing as R2. The value 0 wraps to all ones.
- R4: While clr_i is low and load_n_i is low, each clock edge copies preset_i into count_o. Transitions on up_i and dn_i in those cycles have no effect on the stored value.
- R5: While clr_i is high, each clock edge sets count_o to 0. This holds whatever the levels of load_n_i, up_i and dn_i.
- R6: carry_n_o is 0 exactly when count_o is all ones and up_i is 0. Otherwise it is 1. The output is combinational, so the pulse tracks the low phase of up_i.
- R7: borrow_n_o is 0 exactly when count_o is 0 and dn_i is 0. Otherwise it is 1. The output is combinational, so the pulse tracks the low phase of dn_i.
- R8: With no count transition, count_o holds its value. If both count inputs rise in the same clock cycle, the value also holds.
- R9: Three stages chained carry-to-up and borrow-to-down, sharing clear and load, behave as one 12-bit up/down counter. This includes the wrap from 4095 to 0 and from 0 to 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Count-up input, idle high; a rising transition steps up |
| dn_i | input | 1 | Count-down input, idle high; a rising transition steps down |
| load_n_i | input | 1 | Active-low parallel preset enable |
| clr_i | input | 1 | Active-high clear, highest priority |
| preset_i | input | WIDTH | Value copied in during load |
| count_o | output | WIDTH | Current count |
| carry_n_o | output | 1 | Active-low overflow pulse for the next stage's up input |
| borrow_n_o | output | 1 | Active-low underflow pulse for the next stage's down input |

## Verification
The bench targets the wraps at 4095 and 0 across the whole chain. A stage that released carry or borrow one cycle late would leave the upper nibbles one step behind, so the 12-bit value would go wrong at every nibble boundary. A directed case pulses up_i while load is active, and another raises clear together with load. A priority swap in either case leaves a stepped or preset value where the preset or zero belongs. A case where both count inputs rise together catches a design that lets one direction win. The carry and borrow levels are sampled during the low phase of the count input. This catches outputs that were registered, or decoded from the wrong terminal value.

// File: rtl/updn_pkg.sv
package updn_pkg;

   // Action chosen for the state register on a given clock edge
   typedef enum logic [2:0] {
      STEP_HOLD = 3'd0,
      STEP_INC  = 3'd1,
      STEP_DEC  = 3'd2,
      STEP_LOAD = 3'd3,
      STEP_CLR  = 3'd4
   } step_t;

   localparam int unsigned MIN_WIDTH = 1;
   localparam int unsigned MAX_WIDTH = 32;

   function automatic bit width_ok(input int unsigned w);
      return (w >= MIN_WIDTH) && (w <= MAX_WIDTH);
   endfunction

endpackage

// File: rtl/updn_edge.sv
// Rising-transition detector for an idle-high count input sampled on clk.
module updn_edge #(
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LEVEL;
      else        prev_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev_q;

   // R2
   rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/updn_steer.sv
// Priority steering: clear, then load, then a single count transition.
module updn_steer
   import updn_pkg::*;
(
   input  logic  clr_i,
   input  logic  load_n_i,
   input  logic  up_rise_i,
   input  logic  dn_rise_i,
   output step_t step_o
);

   always_comb begin
      step_o = STEP_HOLD;
      if (clr_i)                       step_o = STEP_CLR;
      else if (!load_n_i)              step_o = STEP_LOAD;
      else if (up_rise_i && !dn_rise_i) step_o = STEP_INC;
      else if (dn_rise_i && !up_rise_i) step_o = STEP_DEC;
   end

endmodule

// File: rtl/updn_core.sv
// State register: every bit changes on the same edge.
module updn_core
   import updn_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  step_t            step_i,
   input  logic [WIDTH-1:0] preset_i,
   output logic [WIDTH-1:0] count_o
);

   localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
   localparam logic [WIDTH-1:0] ZERO = '0;

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      unique case (step_i)
         STEP_CLR:  cnt_d = ZERO;
         STEP_LOAD: cnt_d = preset_i;
         STEP_INC:  cnt_d = cnt_q + ONE;
         STEP_DEC:  cnt_d = cnt_q - ONE;
         default:   cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= ZERO;
      else        cnt_q <= cnt_d;
   end

   assign count_o = cnt_q;

   // R2
   inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i == STEP_INC |=> count_o == $past(count_o) + ONE);
   // R3
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i == STEP_DEC |=> count_o == $past(count_o) - ONE);
   // R8
   hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_i == STEP_HOLD |=> $stable(count_o));

endmodule

// File: rtl/updn_term.sv
// Terminal-count pulses gated by the level of the active count input.
module updn_term #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] count_i,
   input  logic             up_i,
   input  logic             dn_i,
   output logic             carry_n_o,
   output logic             borrow_n_o
);

   localparam logic [WIDTH-1:0] TOP = '1;
   localparam logic [WIDTH-1:0] BOT = '0;

   logic at_top;
   logic at_bot;

   assign at_top     = (count_i == TOP);
   assign at_bot     = (count_i == BOT);
   assign carry_n_o  = ~(at_top & ~up_i);
   assign borrow_n_o = ~(at_bot & ~dn_i);

   // R6
   carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !carry_n_o |-> (count_i == TOP) && !up_i);
   // R7
   borrow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !borrow_n_o |-> (count_i == BOT) && !dn_i);
   // R6
   carry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_i |-> carry_n_o);

endmodule

// File: rtl/updn_stage.sv
module updn_stage
   import updn_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_i,
   input  logic             dn_i,
   input  logic             load_n_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] preset_i,
   output logic [WIDTH-1:0] count_o,
   output logic             carry_n_o,
   output logic             borrow_n_o
);

   localparam bit COUNT_IDLE = 1'b1;

   if (!width_ok(WIDTH)) begin : g_bad_width
      $error("updn_stage: WIDTH out of supported range");
   end

   logic  up_rise;
   logic  dn_rise;
   step_t step;

   updn_edge #(.IDLE_LEVEL(COUNT_IDLE)) u_up_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(up_i), .rise_o(up_rise)
   );

   updn_edge #(.IDLE_LEVEL(COUNT_IDLE)) u_dn_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(dn_i), .rise_o(dn_rise)
   );

   updn_steer u_steer (
      .clr_i(clr_i), .load_n_i(load_n_i),
      .up_rise_i(up_rise), .dn_rise_i(dn_rise), .step_o(step)
   );

   updn_core #(.WIDTH(WIDTH)) u_core (
      .clk(clk), .rst_n(rst_n), .step_i(step),
      .preset_i(preset_i), .count_o(count_o)
   );

   updn_term #(.WIDTH(WIDTH)) u_term (
      .clk(clk), .rst_n(rst_n), .count_i(count_o),
      .up_i(up_i), .dn_i(dn_i),
      .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
   );

   // R5
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> count_o == '0);
   // R4
   load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !load_n_i) |=> count_o == $past(preset_i));
   // R8
   both_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && load_n_i && up_rise && dn_rise) |=> $stable(count_o));

endmodule

// File: tb/updn_stage_test.sv
module updn_stage_test;

   localparam int CLK_PERIOD = 10;
   localparam int W = 4;
   localparam int N = 3 * W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up = 1'b1, dn = 1'b1, load_n = 1'b1, clr = 1'b0;
   logic [N-1:0] preset = '0;

   logic [W-1:0] c0, c1, c2;
   logic cy0, cy1, cy2, bw0, bw1, bw2;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   updn_stage #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .up_i(up), .dn_i(dn), .load_n_i(load_n),
      .clr_i(clr), .preset_i(preset[W-1:0]), .count_o(c0),
      .carry_n_o(cy0), .borrow_n_o(bw0));
   updn_stage #(.WIDTH(W)) mid (
      .clk(clk), .rst_n(rst_n), .up_i(cy0), .dn_i(bw0), .load_n_i(load_n),
      .clr_i(clr), .preset_i(preset[2*W-1:W]), .count_o(c1),
      .carry_n_o(cy1), .borrow_n_o(bw1));
   updn_stage #(.WIDTH(W)) top (
      .clk(clk), .rst_n(rst_n), .up_i(cy1), .dn_i(bw1), .load_n_i(load_n),
      .clr_i(clr), .preset_i(preset[N-1:2*W]), .count_o(c2),
      .carry_n_o(cy2), .borrow_n_o(bw2));

   function automatic logic exp_carry(input logic [N-1:0] v, input int bits, input logic lvl);
      logic [N-1:0] mask = (N'(1) << bits) - N'(1);
      return !(((v & mask) == mask) && !lvl);
   endfunction

   function automatic logic exp_borrow(input logic [N-1:0] v, input int bits, input logic lvl);
      logic [N-1:0] mask = (N'(1) << bits) - N'(1);
      return !(((v & mask) == '0) && !lvl);
   endfunction

   task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   task automatic check_value(input string req);
      check(req, {c2, c1, c0}, model);
   endtask

   task automatic pulse_up(input string req);
      @(negedge clk); up = 1'b0;
      #1;
      check("R6 stage carry", N'(cy0), N'(exp_carry(model, W, 1'b0)));
      check("R9 chain carry", N'(cy2), N'(exp_carry(model, N, 1'b0)));
      @(negedge clk); up = 1'b1;
      model = model + N'(1);
      @(negedge clk);
      check_value(req);
   endtask

   task automatic pulse_dn(input string req);
      @(negedge clk); dn = 1'b0;
      #1;
      check("R7 stage borrow", N'(bw0), N'(exp_borrow(model, W, 1'b0)));
      check("R9 chain borrow", N'(bw2), N'(exp_borrow(model, N, 1'b0)));
      @(negedge clk); dn = 1'b1;
      model = model - N'(1);
      @(negedge clk);
      check_value(req);
   endtask

   task automatic do_load(input logic [N-1:0] v);
      @(negedge clk); load_n = 1'b0; preset = v;
      @(negedge clk); load_n = 1'b1;
      model = v;
      check_value("R4 load");
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      model = '0;
      check_value("R5 clear");
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd1931));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_value("R1 count");
      check("R1 carry", N'(cy0), N'(1));
      check("R1 borrow", N'(bw0), N'(1));

      // R2 / R9 wrap through every stage at the top
      do_load(N'(4094));
      pulse_up("R2 up");
      pulse_up("R9 wrap 4095->0");
      // R3 / R9 wrap at zero
      pulse_dn("R9 wrap 0->4095");
      pulse_dn("R3 down");

      // R4 count transition during load is ignored
      @(negedge clk); load_n = 1'b0; preset = N'(12'h5a3); up = 1'b0;
      @(negedge clk); up = 1'b1;
      @(negedge clk); load_n = 1'b1;
      model = N'(12'h5a3);
      @(negedge clk);
      check_value("R4 load ignores up");

      // R5 clear overrides load
      @(negedge clk); clr = 1'b1; load_n = 1'b0; preset = N'(12'h777);
      @(negedge clk); clr = 1'b0; load_n = 1'b1;
      model = '0;
      check_value("R5 clear over load");

      // R8 both count inputs rise together: hold
      do_load(N'(12'h126));
      @(negedge clk); up = 1'b0; dn = 1'b0;
      @(negedge clk); up = 1'b1; dn = 1'b1;
      @(negedge clk);
      check_value("R8 both rise");
      // R8 idle cycles: hold
      repeat (4) @(negedge clk);
      check_value("R8 idle hold");

      // Random mix; R9 compares the full chained value each time
      for (int i = 0; i < 600; i++) begin
         int unsigned op = $urandom_range(0, 19);
         if (op < 9)       pulse_up("R2 R9 random up");
         else if (op < 18) pulse_dn("R3 R9 random down");
         else if (op < 19) do_load(N'($urandom_range(0, 4095)));
         else              do_clear();
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule